// File: doc/BRIEF.md
# Per-Lane Link Event Counter

This block counts one kind of link-layer event on one lane of a multi-lane serial link controller. Each lane supplies single-cycle strobes for two families of events. The first is link-packet activity: ACK and flow-control-update packets sent and received, nullified packets and received duplicates. The second is transaction counts split by request and completion type, sent and received. Software writes a 32-bit control word to choose one event and one lane and to issue enable, disable or clear commands. It reads the running count from a 32-bit data word.

The choice of event is packed as a family number and an event index within that family. The enable and clear requests are multi-bit command codes, so a code that is not recognised changes nothing. The count is never reset by selecting a new event or by disabling. It returns to zero only through the explicit clear command or a block reset. The counter is a free-running modular counter with a parameterised width (32 bits by default).

Top module: `lane_evt_counter`

## Requirements
- R1: After reset the count is 0, counting is disabled, and the control word reads back as 0.
- R2: The control word is at byte offset 0x08 and the count at 0x0C. Any other offset reads 0. A write to 0x0C has no effect on the count.
- R3: Control bits 27:24 carry the family number and bits 23:16 carry the event index. Family 6 has indices 0 to 6 and family 7 has indices 0 to 23 (0x17). For lane L and index e, family 6 uses strobe `grp_a_evt_i[L*7+e]` and family 7 uses strobe `grp_b_evt_i[L*24+e]`. Both fields read back at the same bit positions.
- R4: Control bits 11:8 choose the lane, and they read back at those bits. Strobes on any other lane, or on any other event, do not change the count.
- R5: Writing code 3 to control bits 4:2 enables counting and writing code 1 disables it. Any other code leaves the enable state as it was. While disabled the count holds.
- R6: Control bit 7 reads 1 while counting is enabled and 0 while disabled. Bits 4:2 and 1:0 always read back 0.
- R7: Writing code 1 to control bits 1:0 sets the count to 0. Any other clear code leaves the count as it was, and so does disabling counting.
- R8: While counting is enabled, each clock edge at which the chosen strobe is high adds exactly 1 to the count. A change of selection or enable takes effect from the edge after the write.
- R9: The count wraps modulo 2^CNT_W. The maximum value is followed by 0.
- R10: If one write carries both the clear code and the enable code, the count is 0 after that write, even if the chosen strobe was high at that edge. Counting then starts at the next edge.
- R11: A family other than 6 or 7, an index beyond the family's range, or a lane number at or above LANES leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Byte offset of the access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| grp_a_evt_i | input | LANES*A_EVTS | Family-6 event strobes, lane-major |
| grp_b_evt_i | input | LANES*B_EVTS | Family-7 event strobes, lane-major |

## Verification
A clear command and a counted strobe can land on the same clock edge. So can a clear and an enable carried in the same write. The bench provokes both. It holds the chosen strobe high through the cycle of a write that clears and enables. It then requires the count to read 0 right after that edge and 1 after one more strobe. Around that case, the bench sweeps every lane and every event of both families. Each case interleaves target pulses with cycles in which every other strobe is high, and the expected count is the number of target pulses.

// File: rtl/lec_pkg.sv
package lec_pkg;

    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_DATA = 8'h0C;

    localparam logic [2:0] EN_CODE_ON  = 3'h3;
    localparam logic [2:0] EN_CODE_OFF = 3'h1;
    localparam logic [1:0] CLR_CODE_GO = 2'h1;

    localparam logic [3:0] FAM_LINKPKT = 4'h6;
    localparam logic [3:0] FAM_XACT    = 4'h7;

    typedef struct packed {
        logic [3:0] fam;
        logic [7:0] idx;
        logic [3:0] lane;
        logic       en;
    } sel_cfg_t;

    typedef struct packed {
        logic       ctrl_wr;
        logic       go_on;
        logic       go_off;
        logic       go_clr;
        logic [3:0] fam;
        logic [7:0] idx;
        logic [3:0] lane;
    } wr_cmd_t;

endpackage

// File: rtl/lec_ctrl_decode.sv
module lec_ctrl_decode
    import lec_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [31:0]   wdata_i,
    output wr_cmd_t       cmd_o
);
    logic hit_ctrl;

    always_comb begin
        hit_ctrl      = we_i && (addr_i == AW'(OFS_CTRL));
        cmd_o.ctrl_wr = hit_ctrl;
        cmd_o.go_on   = hit_ctrl && (wdata_i[4:2] == EN_CODE_ON);
        cmd_o.go_off  = hit_ctrl && (wdata_i[4:2] == EN_CODE_OFF);
        cmd_o.go_clr  = hit_ctrl && (wdata_i[1:0] == CLR_CODE_GO);
        cmd_o.fam     = wdata_i[27:24];
        cmd_o.idx     = wdata_i[23:16];
        cmd_o.lane    = wdata_i[11:8];
    end

endmodule

// File: rtl/lec_evt_select.sv
module lec_evt_select
    import lec_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int A_EVTS = 7,
    parameter int B_EVTS = 24
) (
    input  logic [3:0]              fam_i,
    input  logic [7:0]              idx_i,
    input  logic [3:0]              lane_i,
    input  logic [LANES*A_EVTS-1:0] grp_a_i,
    input  logic [LANES*B_EVTS-1:0] grp_b_i,
    output logic                    hit_o
);
    logic [LANES-1:0] lane_hit;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic a_hit;
        logic b_hit;
        always_comb begin
            a_hit = 1'b0;
            b_hit = 1'b0;
            for (int e = 0; e < A_EVTS; e++) begin
                if (idx_i == 8'(e)) a_hit = grp_a_i[l*A_EVTS+e];
            end
            for (int e = 0; e < B_EVTS; e++) begin
                if (idx_i == 8'(e)) b_hit = grp_b_i[l*B_EVTS+e];
            end
            lane_hit[l] = (lane_i == 4'(l)) &&
                          (((fam_i == FAM_LINKPKT) && a_hit) ||
                           ((fam_i == FAM_XACT) && b_hit));
        end
    end

    assign hit_o = |lane_hit;

endmodule

// File: rtl/lec_readback.sv
module lec_readback
    import lec_pkg::*;
#(
    parameter int AW    = 8,
    parameter int CNT_W = 32
) (
    input  logic [AW-1:0]    addr_i,
    input  sel_cfg_t         cfg_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [31:0]      rdata_o
);
    logic [31:0] cnt_ext;

    if (CNT_W < 32) begin : g_pad
        assign cnt_ext = {{(32-CNT_W){1'b0}}, cnt_i};
    end else begin : g_full
        assign cnt_ext = cnt_i[31:0];
    end

    always_comb begin
        rdata_o = 32'h0;
        if (addr_i == AW'(OFS_CTRL)) begin
            rdata_o[27:24] = cfg_i.fam;
            rdata_o[23:16] = cfg_i.idx;
            rdata_o[11:8]  = cfg_i.lane;
            rdata_o[7]     = cfg_i.en;
        end else if (addr_i == AW'(OFS_DATA)) begin
            rdata_o = cnt_ext;
        end
    end

endmodule

// File: rtl/lane_evt_counter.sv
module lane_evt_counter
    import lec_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int A_EVTS = 7,
    parameter int B_EVTS = 24,
    parameter int CNT_W  = 32,
    parameter int AW     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we_i,
    input  logic [AW-1:0]           reg_addr_i,
    input  logic [31:0]             reg_wdata_i,
    output logic [31:0]             reg_rdata_o,
    input  logic [LANES*A_EVTS-1:0] grp_a_evt_i,
    input  logic [LANES*B_EVTS-1:0] grp_b_evt_i
);
    typedef struct packed {
        sel_cfg_t         cfg;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t  st_d, st_q;
    wr_cmd_t cmd;
    logic    evt_hit;

    lec_ctrl_decode #(.AW(AW)) u_dec (
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .cmd_o   (cmd)
    );

    lec_evt_select #(.LANES(LANES), .A_EVTS(A_EVTS), .B_EVTS(B_EVTS)) u_sel (
        .fam_i   (st_q.cfg.fam),
        .idx_i   (st_q.cfg.idx),
        .lane_i  (st_q.cfg.lane),
        .grp_a_i (grp_a_evt_i),
        .grp_b_i (grp_b_evt_i),
        .hit_o   (evt_hit)
    );

    lec_readback #(.AW(AW), .CNT_W(CNT_W)) u_rb (
        .addr_i  (reg_addr_i),
        .cfg_i   (st_q.cfg),
        .cnt_i   (st_q.cnt),
        .rdata_o (reg_rdata_o)
    );

    always_comb begin
        st_d = st_q;
        if (cmd.ctrl_wr) begin
            st_d.cfg.fam  = cmd.fam;
            st_d.cfg.idx  = cmd.idx;
            st_d.cfg.lane = cmd.lane;
            if (cmd.go_on)       st_d.cfg.en = 1'b1;
            else if (cmd.go_off) st_d.cfg.en = 1'b0;
        end
        if (st_q.cfg.en && evt_hit) st_d.cnt = st_q.cnt + CNT_W'(1);
        if (cmd.go_clr)             st_d.cnt = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: an accepted clear leaves the count at zero
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.go_clr |=> (st_q.cnt == '0));

    // R8/R9: the count moves by at most one step (or to zero on clear)
    p_single_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.cnt == $past(st_q.cnt)) ||
                  (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)) ||
                  (st_q.cnt == '0)));

    // R5: while disabled and not cleared the count holds
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.cfg.en && !cmd.go_clr) |=> $stable(st_q.cnt));

    // R5: unknown enable codes keep the enable state
    p_bad_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.ctrl_wr && !cmd.go_on && !cmd.go_off) |=> $stable(st_q.cfg.en));

    // R5: the on code enables counting
    p_turn_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.go_on |=> st_q.cfg.en);

    // R11: without a selected strobe the count only changes by clear
    p_no_hit_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_hit && !cmd.go_clr) |=> $stable(st_q.cnt));

endmodule

// File: tb/lane_evt_counter_tb_top.sv
module lane_evt_counter_tb_top;
    localparam int LN = 4;
    localparam int NA = 7;
    localparam int NB = 24;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we = 1'b0;
    logic [7:0] addr = 8'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic [LN*NA-1:0] ga = '0;
    logic [LN*NB-1:0] gb = '0;
    logic [LN*NA-1:0] ta;
    logic [LN*NB-1:0] tb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lane_evt_counter #(.LANES(LN), .A_EVTS(NA), .B_EVTS(NB), .CNT_W(CW), .AW(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .grp_a_evt_i(ga), .grp_b_evt_i(gb)
    );

    function automatic logic [31:0] mk(input logic [3:0] f, input logic [7:0] e,
                                       input logic [3:0] l, input logic [2:0] en,
                                       input logic [1:0] cl);
        return {4'h0, f, e, 4'h0, l, 3'b000, en, cl};
    endfunction

    function automatic logic [31:0] rb(input logic [3:0] f, input logic [7:0] e,
                                       input logic [3:0] l, input logic on);
        return {4'h0, f, e, 4'h0, l, on, 7'h0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    task automatic target(input int l, input int f, input int e);
        ta = '0;
        tb = '0;
        if (f == 6) ta[l*NA+e] = 1'b1;
        else        tb[l*NB+e] = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1 check(req, rdata, exp);
    endtask

    task automatic pulse(input logic [LN*NA-1:0] a, input logic [LN*NB-1:0] b);
        @(negedge clk);
        ga = a; gb = b;
        @(posedge clk);
        #1 ga = '0; gb = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog act=hung exp=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd("R1 ctrl", 8'h08, 32'h0);
        rd("R1 data", 8'h0C, 32'h0);

        // R3 R4 R8 sweep: every lane, every event of both families
        for (int l = 0; l < LN; l++) begin
            for (int f = 6; f <= 7; f++) begin
                for (int e = 0; e < ((f == 6) ? NA : NB); e++) begin
                    int n;
                    n = (l * 3 + e) % 5 + 1;
                    wr(8'h08, mk(4'(f), 8'(e), 4'(l), 3'h3, 2'h1));
                    target(l, f, e);
                    for (int i = 0; i < n; i++) begin
                        pulse(ta, tb);
                        pulse(~ta, ~tb);
                    end
                    rd("R8 R4 sweep count", 8'h0C, 32'(n));
                    rd("R3 R6 readback", 8'h08, rb(4'(f), 8'(e), 4'(l), 1'b1));
                end
            end
        end

        // Current selection: lane 2, family 7, index 5
        wr(8'h08, mk(4'h7, 8'h05, 4'h2, 3'h3, 2'h1));
        target(2, 7, 5);
        repeat (4) pulse(ta, tb);
        rd("R8 four pulses", 8'h0C, 32'd4);

        // R2: data write ignored, other offsets read 0
        wr(8'h0C, 32'hFFFF_FFFF);
        rd("R2 data write ignored", 8'h0C, 32'd4);
        rd("R2 unused offset", 8'h10, 32'h0);
        rd("R2 unused offset 0", 8'h00, 32'h0);

        // R5: bad enable code keeps on
        wr(8'h08, mk(4'h7, 8'h05, 4'h2, 3'h5, 2'h0));
        rd("R5 bad code keeps on", 8'h08, rb(4'h7, 8'h05, 4'h2, 1'b1));
        pulse(ta, tb);
        rd("R5 still counting", 8'h0C, 32'd5);

        // R7: bad clear code ignored
        wr(8'h08, mk(4'h7, 8'h05, 4'h2, 3'h0, 2'h2));
        rd("R7 bad clear ignored", 8'h0C, 32'd5);

        // R5 R6 R7: disable holds and does not clear
        wr(8'h08, mk(4'h7, 8'h05, 4'h2, 3'h1, 2'h0));
        rd("R6 status off", 8'h08, rb(4'h7, 8'h05, 4'h2, 1'b0));
        repeat (3) pulse(ta, tb);
        rd("R5 R7 hold while off", 8'h0C, 32'd5);
        wr(8'h08, mk(4'h7, 8'h05, 4'h2, 3'h2, 2'h0));
        rd("R5 bad code keeps off", 8'h08, rb(4'h7, 8'h05, 4'h2, 1'b0));
        pulse(ta, tb);
        rd("R5 still off", 8'h0C, 32'd5);

        // R11: unmatched family, index, lane
        wr(8'h08, mk(4'h5, 8'h00, 4'h0, 3'h3, 2'h0));
        repeat (3) pulse('1, '1);
        rd("R11 family 5", 8'h0C, 32'd5);
        wr(8'h08, mk(4'h6, 8'h07, 4'h0, 3'h0, 2'h0));
        repeat (3) pulse('1, '1);
        rd("R11 index beyond family", 8'h0C, 32'd5);
        wr(8'h08, mk(4'h7, 8'h00, 4'h5, 3'h0, 2'h0));
        repeat (3) pulse('1, '1);
        rd("R11 lane beyond LANES", 8'h0C, 32'd5);

        // R10: clear + enable in one write with strobe high at that edge
        wr(8'h08, mk(4'h6, 8'h00, 4'h0, 3'h3, 2'h0));
        target(0, 6, 0);
        pulse(ta, tb);
        rd("R8 resumed", 8'h0C, 32'd6);
        @(negedge clk);
        we = 1'b1; addr = 8'h08; wdata = mk(4'h6, 8'h00, 4'h0, 3'h3, 2'h1);
        ga = ta;
        @(posedge clk);
        #1 we = 1'b0; ga = '0;
        rd("R10 clear wins", 8'h0C, 32'd0);
        pulse(ta, tb);
        rd("R10 counts next edge", 8'h0C, 32'd1);

        // R7: clear while disabled
        wr(8'h08, mk(4'h6, 8'h00, 4'h0, 3'h1, 2'h0));
        wr(8'h08, mk(4'h6, 8'h00, 4'h0, 3'h0, 2'h1));
        rd("R7 clear while off", 8'h0C, 32'd0);

        // R9: wrap at 2^CW
        wr(8'h08, mk(4'h6, 8'h03, 4'h3, 3'h3, 2'h1));
        target(3, 6, 3);
        @(negedge clk);
        ga = ta;
        repeat (255) @(posedge clk);
        #1 ga = '0;
        rd("R9 max value", 8'h0C, 32'd255);
        pulse(ta, tb);
        rd("R9 wrap to zero", 8'h0C, 32'd0);
        repeat (2) pulse(ta, tb);
        rd("R9 after wrap", 8'h0C, 32'd2);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule